// File: doc/BRIEF.md
# Decode-Stage Branch Hazard and Redirect Unit

This block is the branch control for a five-stage in-order pipeline (fetch, decode, execute, memory, writeback) in which conditional branches are resolved in decode. Each cycle it looks at the two source registers of the branch sitting in decode. It compares them with the destination registers of the instructions further down the pipeline. From that it decides whether the branch can see its operands this cycle, must wait, or can take one of them from a later stage. It then compares the two operands for equality with its own comparator and computes the branch target with its own adder.

The unit holds the fetch program counter. While the branch waits, the unit freezes the program counter and the fetch/decode register and asks for an empty control bundle to enter execute. Fetch assumes the branch is not taken. When a branch resolves taken, the unit steers the program counter to the target and raises a one-cycle flush for the sequential instruction that was fetched behind it. The register file, ALU and memories sit outside the block. Each cycle the surrounding pipeline presents the producer fields and the result values of the later stages.

Top module: `branch_hazard_unit`

## Requirements
- R1: While reset is low at a clock edge, the fetch program counter loads the parameter RESET_PC (default 0x100). After reset, with no branch in decode, no stall and no flush are raised.
- R2: A branch in decode stalls when either source register is written by the instruction in execute, whether that instruction is an ALU operation or a load. Stalling means `pc_hold`, `ifid_hold` and `idex_bubble` are all 1.
- R3: A load in execute that writes a compared register therefore costs two stall cycles: one while the load is in execute, and a second after it has moved to memory.
- R4: A branch in decode stalls for one cycle when a compared register is written by a load in the memory stage (`mem_memread`=1).
- R5: A compared register written by a non-load in the memory stage is forwarded without a stall. Its select code is 1, and the comparator uses `mem_alu_val`.
- R6: A compared register written by the instruction in writeback is forwarded without a stall. Its select code is 2, and the comparator uses `wb_val`.
- R7: When the memory-stage and writeback producers both write the same compared register, select code 1 (memory stage) wins.
- R8: Register 0 never creates a dependency, and neither does a producer whose register-write flag is 0. In both cases the select code is 0 (register-file value) and no stall results.
- R9: A branch that is not stalled and whose two operands are equal is taken. `br_taken` and `ifid_flush` are 1 for that cycle. `br_target` equals `id_pc_plus4` plus the sign-extended offset shifted left by two, and the program counter loads that target at the next edge.
- R10: When stalled, the program counter keeps its value at the next edge. When neither stalled nor taken, it advances by 4.
- R11: With no branch in decode (`id_is_branch`=0), no stall and no flush are raised, whatever the producer fields hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| id_is_branch | input | 1 | A conditional equality branch occupies decode |
| id_rs | input | AW (5) | First compared source register |
| id_rt | input | AW (5) | Second compared source register |
| id_pc_plus4 | input | XLEN (32) | Address of the branch plus 4 |
| id_offset | input | OFFW (16) | Signed word offset of the branch |
| rf_rs_val | input | XLEN (32) | Register-file value of `id_rs` |
| rf_rt_val | input | XLEN (32) | Register-file value of `id_rt` |
| ex_rd | input | AW (5) | Destination register of the execute-stage instruction |
| ex_regwrite | input | 1 | Execute-stage instruction writes a register |
| mem_rd | input | AW (5) | Destination register of the memory-stage instruction |
| mem_regwrite | input | 1 | Memory-stage instruction writes a register |
| mem_memread | input | 1 | Memory-stage instruction is a load |
| mem_alu_val | input | XLEN (32) | ALU result held in the memory stage |
| wb_rd | input | AW (5) | Destination register of the writeback-stage instruction |
| wb_regwrite | input | 1 | Writeback-stage instruction writes a register |
| wb_val | input | XLEN (32) | Value being written back |
| pc | output | XLEN (32) | Fetch program counter |
| pc_hold | output | 1 | Keep the program counter |
| ifid_hold | output | 1 | Keep the fetch/decode register |
| idex_bubble | output | 1 | Send an all-zero control bundle into execute |
| fwd_a_sel | output | 2 | Source of the first operand: 0 register file, 1 memory stage, 2 writeback |
| fwd_b_sel | output | 2 | Source of the second operand, same codes |
| br_taken | output | 1 | Branch resolved taken this cycle |
| br_target | output | XLEN (32) | Computed branch target |
| ifid_flush | output | 1 | Turn the fetched instruction into a bubble |

## Verification
A wrong producer match or priority shows up in the same cycle as a wrong select code on `fwd_a_sel`/`fwd_b_sel`. It can also show up as a stall raised or dropped, or as a taken decision made from the wrong operand. A fault in the program counter path or in the redirect becomes visible one edge later on `pc`. After a hold, the counter has moved; after a taken branch, it holds something other than the target; or it steps by something other than 4. The bench therefore compares every output on every cycle against its reference model, including the load sequences that must produce two stall cycles in a row.

// File: rtl/bhz_pkg.sv
// Shared types of the decode-stage branch hazard unit.
// Assumes: one equality branch at most in decode per cycle.
package bhz_pkg;

    // Where a comparator operand is taken from; the codes appear on ports.
    typedef enum logic [1:0] {
        SRC_REGFILE = 2'd0,
        SRC_MEM     = 2'd1,
        SRC_WB      = 2'd2
    } opnd_src_e;

endpackage

// File: rtl/bhz_dep_check.sv
// Dependency check for one comparator operand.
// Decides whether the operand is not yet available (stall) and from which
// later stage it should be forwarded. Assumes register 0 is hard-wired zero.
module bhz_dep_check
    import bhz_pkg::*;
#(
    parameter int AW = 5
) (
    input  logic [AW-1:0] src,
    input  logic [AW-1:0] ex_rd,
    input  logic          ex_we,
    input  logic [AW-1:0] mem_rd,
    input  logic          mem_we,
    input  logic          mem_ld,
    input  logic [AW-1:0] wb_rd,
    input  logic          wb_we,
    output logic          need_stall,
    output opnd_src_e     src_sel
);

    logic src_live;
    logic ex_hit;
    logic mem_hit;
    logic wb_hit;

    // Match the operand against each producer that really writes it.
    always_comb begin
        src_live = (src != '0);
        ex_hit   = src_live && ex_we  && (ex_rd  == src);
        mem_hit  = src_live && mem_we && (mem_rd == src);
        wb_hit   = src_live && wb_we  && (wb_rd  == src);
    end

    // An execute producer or a memory-stage load cannot feed decode yet.
    always_comb begin
        need_stall = ex_hit || (mem_hit && mem_ld);
    end

    // The youngest forwardable producer wins.
    always_comb begin
        if (mem_hit) begin
            src_sel = SRC_MEM;
        end else if (wb_hit) begin
            src_sel = SRC_WB;
        end else begin
            src_sel = SRC_REGFILE;
        end
    end

endmodule

// File: rtl/bhz_id_compare.sv
// Decode-stage operand selection, equality comparator and target adder.
// Assumes the offset counts words, so it is shifted left by two.
module bhz_id_compare
    import bhz_pkg::*;
#(
    parameter int XLEN = 32,
    parameter int OFFW = 16
) (
    input  opnd_src_e        sel_a,
    input  opnd_src_e        sel_b,
    input  logic [XLEN-1:0]  rf_a,
    input  logic [XLEN-1:0]  rf_b,
    input  logic [XLEN-1:0]  mem_val,
    input  logic [XLEN-1:0]  wb_val,
    input  logic [XLEN-1:0]  pc_plus4,
    input  logic [OFFW-1:0]  offset,
    output logic             equal,
    output logic [XLEN-1:0]  target
);

    localparam int EXT_W = XLEN - OFFW;

    logic [XLEN-1:0] opnd_a;
    logic [XLEN-1:0] opnd_b;
    logic [XLEN-1:0] off_ext;

    // Choose the value of an operand from its select code.
    function automatic logic [XLEN-1:0] pick(input opnd_src_e sel,
                                             input logic [XLEN-1:0] rf_v,
                                             input logic [XLEN-1:0] mem_v,
                                             input logic [XLEN-1:0] wb_v);
        case (sel)
            SRC_MEM: pick = mem_v;
            SRC_WB:  pick = wb_v;
            default: pick = rf_v;
        endcase
    endfunction

    // Build both operands and compare them.
    always_comb begin
        opnd_a = pick(sel_a, rf_a, mem_val, wb_val);
        opnd_b = pick(sel_b, rf_b, mem_val, wb_val);
        equal  = (opnd_a == opnd_b);
    end

    // Sign-extend the word offset and add it to the sequential address.
    always_comb begin
        off_ext = {{EXT_W{offset[OFFW-1]}}, offset};
        target  = pc_plus4 + (off_ext << 2);
    end

endmodule

// File: rtl/bhz_pc_reg.sv
// Fetch program counter with hold and redirect.
// Assumes hold and redirect are never both set; hold takes priority.
module bhz_pc_reg #(
    parameter int              XLEN     = 32,
    parameter logic [XLEN-1:0] RESET_PC = 32'h0000_0100
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            hold,
    input  logic            redirect,
    input  logic [XLEN-1:0] target,
    output logic [XLEN-1:0] pc
);

    localparam logic [XLEN-1:0] STEP = XLEN'(4);

    // Advance, hold or redirect the fetch address each cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pc <= RESET_PC;
        end else if (hold) begin
            pc <= pc;
        end else if (redirect) begin
            pc <= target;
        end else begin
            pc <= pc + STEP;
        end
    end

endmodule

// File: rtl/branch_hazard_unit.sv
// Decode-stage branch hazard and redirect unit.
// Checks both branch operands against the execute, memory and writeback
// producers, stalls or forwards, resolves the branch, and keeps the fetch
// program counter. Assumes the pipeline flushes the next instruction when
// ifid_flush is set and zeroes execute control when idex_bubble is set.
module branch_hazard_unit
    import bhz_pkg::*;
#(
    parameter int              XLEN     = 32,
    parameter int              AW       = 5,
    parameter int              OFFW     = 16,
    parameter logic [XLEN-1:0] RESET_PC = 32'h0000_0100
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            id_is_branch,
    input  logic [AW-1:0]   id_rs,
    input  logic [AW-1:0]   id_rt,
    input  logic [XLEN-1:0] id_pc_plus4,
    input  logic [OFFW-1:0] id_offset,
    input  logic [XLEN-1:0] rf_rs_val,
    input  logic [XLEN-1:0] rf_rt_val,
    input  logic [AW-1:0]   ex_rd,
    input  logic            ex_regwrite,
    input  logic [AW-1:0]   mem_rd,
    input  logic            mem_regwrite,
    input  logic            mem_memread,
    input  logic [XLEN-1:0] mem_alu_val,
    input  logic [AW-1:0]   wb_rd,
    input  logic            wb_regwrite,
    input  logic [XLEN-1:0] wb_val,
    output logic [XLEN-1:0] pc,
    output logic            pc_hold,
    output logic            ifid_hold,
    output logic            idex_bubble,
    output logic [1:0]      fwd_a_sel,
    output logic [1:0]      fwd_b_sel,
    output logic            br_taken,
    output logic [XLEN-1:0] br_target,
    output logic            ifid_flush
);

    localparam int NOPND = 2;

    logic [AW-1:0] src_reg [NOPND];
    opnd_src_e     src_sel [NOPND];
    logic [NOPND-1:0] need_stall;
    logic          stall;
    logic          opnd_equal;

    // Route the two compared registers to their checkers.
    always_comb begin
        src_reg[0] = id_rs;
        src_reg[1] = id_rt;
    end

    // One dependency checker per comparator operand.
    for (genvar g = 0; g < NOPND; g++) begin : g_opnd
        bhz_dep_check #(.AW(AW)) u_dep (
            .src        (src_reg[g]),
            .ex_rd      (ex_rd),
            .ex_we      (ex_regwrite),
            .mem_rd     (mem_rd),
            .mem_we     (mem_regwrite),
            .mem_ld     (mem_memread),
            .wb_rd      (wb_rd),
            .wb_we      (wb_regwrite),
            .need_stall (need_stall[g]),
            .src_sel    (src_sel[g])
        );
    end

    bhz_id_compare #(.XLEN(XLEN), .OFFW(OFFW)) u_cmp (
        .sel_a    (src_sel[0]),
        .sel_b    (src_sel[1]),
        .rf_a     (rf_rs_val),
        .rf_b     (rf_rt_val),
        .mem_val  (mem_alu_val),
        .wb_val   (wb_val),
        .pc_plus4 (id_pc_plus4),
        .offset   (id_offset),
        .equal    (opnd_equal),
        .target   (br_target)
    );

    // Stall only for a branch; resolve only when not stalled.
    always_comb begin
        stall    = id_is_branch && (|need_stall);
        br_taken = id_is_branch && !stall && opnd_equal;
    end

    // Drive the pipeline control outputs.
    always_comb begin
        pc_hold     = stall;
        ifid_hold   = stall;
        idex_bubble = stall;
        ifid_flush  = br_taken;
        fwd_a_sel   = src_sel[0];
        fwd_b_sel   = src_sel[1];
    end

    bhz_pc_reg #(.XLEN(XLEN), .RESET_PC(RESET_PC)) u_pc (
        .clk      (clk),
        .rst_n    (rst_n),
        .hold     (stall),
        .redirect (br_taken),
        .target   (br_target),
        .pc       (pc)
    );

endmodule

// File: rtl/bhz_checker.sv
// Temporal checks of the branch hazard unit, attached by bind.
module bhz_checker #(
    parameter int              XLEN     = 32,
    parameter int              AW       = 5,
    parameter logic [XLEN-1:0] RESET_PC = 32'h0000_0100
) (
    input logic            clk,
    input logic            rst_n,
    input logic            id_is_branch,
    input logic [AW-1:0]   id_rs,
    input logic [AW-1:0]   id_rt,
    input logic [AW-1:0]   ex_rd,
    input logic            ex_regwrite,
    input logic [AW-1:0]   mem_rd,
    input logic            mem_regwrite,
    input logic            mem_memread,
    input logic [XLEN-1:0] pc,
    input logic            pc_hold,
    input logic [1:0]      fwd_a_sel,
    input logic            br_taken,
    input logic [XLEN-1:0] br_target,
    input logic            ifid_flush
);

    AST_RESET_PC: assert property (@(posedge clk) !rst_n |=> pc == RESET_PC); // R1

    AST_EX_PRODUCER_STALLS: assert property (@(posedge clk) disable iff (!rst_n)
        (id_is_branch && ex_regwrite && ex_rd != '0 && (ex_rd == id_rs || ex_rd == id_rt))
        |-> pc_hold); // R2

    AST_MEM_LOAD_STALLS: assert property (@(posedge clk) disable iff (!rst_n)
        (id_is_branch && mem_regwrite && mem_memread && mem_rd != '0 &&
         (mem_rd == id_rs || mem_rd == id_rt)) |-> pc_hold); // R4

    AST_MEM_WINS_FORWARD: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_regwrite && mem_rd != '0 && mem_rd == id_rs) |-> fwd_a_sel == 2'd1); // R7

    AST_TAKEN_REDIRECTS: assert property (@(posedge clk) disable iff (!rst_n)
        br_taken |=> pc == $past(br_target)); // R9

    AST_FLUSH_NEVER_STALLED: assert property (@(posedge clk) disable iff (!rst_n)
        ifid_flush |-> !pc_hold); // R9

    AST_HOLD_KEEPS_PC: assert property (@(posedge clk) disable iff (!rst_n)
        pc_hold |=> $stable(pc)); // R10

    AST_SEQUENTIAL_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (!pc_hold && !br_taken) |=> pc == $past(pc) + XLEN'(4)); // R10

    AST_NO_BRANCH_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !id_is_branch |-> (!pc_hold && !ifid_flush)); // R11

endmodule

bind branch_hazard_unit bhz_checker #(
    .XLEN(XLEN), .AW(AW), .RESET_PC(RESET_PC)
) u_bhz_checker (
    .clk          (clk),
    .rst_n        (rst_n),
    .id_is_branch (id_is_branch),
    .id_rs        (id_rs),
    .id_rt        (id_rt),
    .ex_rd        (ex_rd),
    .ex_regwrite  (ex_regwrite),
    .mem_rd       (mem_rd),
    .mem_regwrite (mem_regwrite),
    .mem_memread  (mem_memread),
    .pc           (pc),
    .pc_hold      (pc_hold),
    .fwd_a_sel    (fwd_a_sel),
    .br_taken     (br_taken),
    .br_target    (br_target),
    .ifid_flush   (ifid_flush)
);

// File: tb/tb_branch_hazard_unit.sv
module tb_branch_hazard_unit;

    localparam int          XLEN     = 32;
    localparam int          AW       = 5;
    localparam int          OFFW     = 16;
    localparam logic [31:0] RESET_PC = 32'h0000_0100;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            id_is_branch = 1'b0;
    logic [AW-1:0]   id_rs = '0, id_rt = '0;
    logic [XLEN-1:0] id_pc_plus4 = '0;
    logic [OFFW-1:0] id_offset = '0;
    logic [XLEN-1:0] rf_rs_val = '0, rf_rt_val = '0;
    logic [AW-1:0]   ex_rd = '0, mem_rd = '0, wb_rd = '0;
    logic            ex_regwrite = 1'b0, mem_regwrite = 1'b0, mem_memread = 1'b0, wb_regwrite = 1'b0;
    logic [XLEN-1:0] mem_alu_val = '0, wb_val = '0;
    logic [XLEN-1:0] pc, br_target;
    logic            pc_hold, ifid_hold, idex_bubble, br_taken, ifid_flush;
    logic [1:0]      fwd_a_sel, fwd_b_sel;

    int          checks = 0;
    int          fails  = 0;
    logic [31:0] exp_pc;

    always #5 clk = ~clk;

    branch_hazard_unit #(.XLEN(XLEN), .AW(AW), .OFFW(OFFW), .RESET_PC(RESET_PC)) dut (
        .clk(clk), .rst_n(rst_n), .id_is_branch(id_is_branch), .id_rs(id_rs), .id_rt(id_rt),
        .id_pc_plus4(id_pc_plus4), .id_offset(id_offset), .rf_rs_val(rf_rs_val),
        .rf_rt_val(rf_rt_val), .ex_rd(ex_rd), .ex_regwrite(ex_regwrite), .mem_rd(mem_rd),
        .mem_regwrite(mem_regwrite), .mem_memread(mem_memread), .mem_alu_val(mem_alu_val),
        .wb_rd(wb_rd), .wb_regwrite(wb_regwrite), .wb_val(wb_val), .pc(pc), .pc_hold(pc_hold),
        .ifid_hold(ifid_hold), .idex_bubble(idex_bubble), .fwd_a_sel(fwd_a_sel),
        .fwd_b_sel(fwd_b_sel), .br_taken(br_taken), .br_target(br_target), .ifid_flush(ifid_flush)
    );

    task automatic chk(input string tag, input string what, input logic [31:0] act, input logic [31:0] expv);
        checks++;
        if (act !== expv) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, expv);
        end
    endtask

    // Reference for one operand: distance 1 = execute, 2 = memory, 3 = writeback.
    function automatic void opnd_ref(input int r, output int sel, output bit stl);
        int  rds [4];
        bit  wes [4];
        bit  lds [4];
        rds[1] = int'(ex_rd);  wes[1] = ex_regwrite;  lds[1] = 1'b0;
        rds[2] = int'(mem_rd); wes[2] = mem_regwrite; lds[2] = mem_memread;
        rds[3] = int'(wb_rd);  wes[3] = wb_regwrite;  lds[3] = 1'b0;
        sel = 0;
        stl = 1'b0;
        for (int d = 1; d <= 3; d++) begin
            if (r != 0 && wes[d] && rds[d] == r) begin
                if (d == 1) stl = 1'b1;
                if (d == 2 && lds[d]) stl = 1'b1;
                if (d >= 2 && sel == 0) sel = d - 1;
            end
        end
    endfunction

    function automatic logic [31:0] val_of(input int sel, input logic [31:0] rfv);
        if (sel == 1) return mem_alu_val;
        if (sel == 2) return wb_val;
        return rfv;
    endfunction

    // Compare every output in the current cycle, then advance the PC model.
    task automatic step(input string tag);
        int          sa, sb;
        bit          ta, tb_, st, tk;
        logic [31:0] tgt;
        #1;
        opnd_ref(int'(id_rs), sa, ta);
        opnd_ref(int'(id_rt), sb, tb_);
        st  = id_is_branch && (ta || tb_);
        tk  = id_is_branch && !st && (val_of(sa, rf_rs_val) == val_of(sb, rf_rt_val));
        tgt = id_pc_plus4 + 32'(int'($signed(id_offset)) * 4);
        chk(tag, "pc", pc, exp_pc);
        chk(tag, "pc_hold", 32'(pc_hold), 32'(st));
        chk(tag, "ifid_hold", 32'(ifid_hold), 32'(st));
        chk(tag, "idex_bubble", 32'(idex_bubble), 32'(st));
        chk(tag, "fwd_a_sel", 32'(fwd_a_sel), 32'(sa));
        chk(tag, "fwd_b_sel", 32'(fwd_b_sel), 32'(sb));
        chk(tag, "br_taken", 32'(br_taken), 32'(tk));
        chk(tag, "ifid_flush", 32'(ifid_flush), 32'(tk));
        chk(tag, "br_target", br_target, tgt);
        @(posedge clk);
        if (!st) exp_pc = tk ? tgt : exp_pc + 32'd4;
        @(negedge clk);
    endtask

    task automatic set_prod(input int erd, input bit ewe, input int mrd, input bit mwe,
                            input bit mld, input int wrd, input bit wwe);
        ex_rd  = AW'(erd); ex_regwrite  = ewe;
        mem_rd = AW'(mrd); mem_regwrite = mwe; mem_memread = mld;
        wb_rd  = AW'(wrd); wb_regwrite  = wwe;
    endtask

    task automatic set_br(input bit v, input int rs, input int rt, input logic [31:0] rsv,
                          input logic [31:0] rtv, input int off);
        id_is_branch = v; id_rs = AW'(rs); id_rt = AW'(rt);
        rf_rs_val = rsv; rf_rt_val = rtv; id_offset = OFFW'(off);
        id_pc_plus4 = exp_pc;
    endtask

    initial begin
        #2_000_000;
        checks++;
        fails++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        exp_pc = RESET_PC;
        mem_alu_val = 32'd7;
        wb_val      = 32'd9;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        set_br(0, 0, 0, 0, 0, 0);
        step("R1 reset state");
        set_prod(1, 1, 0, 0, 0, 0, 0);
        set_br(0, 1, 2, 0, 0, 3);
        step("R11 no branch with producer match");
        set_br(1, 1, 2, 4, 4, 3);
        step("R2 ALU in execute stalls");
        step("R10 pc held during stall");
        set_prod(0, 0, 1, 1, 0, 0, 0);
        set_br(1, 1, 2, 3, 7, 5);
        step("R5 memory forward and R9 taken");
        set_prod(0, 0, 0, 0, 0, 0, 0);
        set_br(0, 0, 0, 0, 0, 0);
        step("R9 redirect to target");
        set_prod(3, 1, 0, 0, 0, 0, 0);
        set_br(1, 3, 0, 1, 9, 2);
        step("R3 load in execute first stall");
        set_prod(0, 0, 3, 1, 1, 0, 0);
        step("R3 R4 load in memory second stall");
        set_prod(0, 0, 0, 0, 0, 3, 1);
        step("R6 writeback forward");
        set_prod(0, 0, 4, 1, 0, 4, 1);
        set_br(1, 4, 5, 0, 9, 1);
        step("R7 memory wins over writeback");
        set_prod(0, 1, 0, 1, 1, 0, 1);
        set_br(1, 0, 0, 2, 2, -3);
        step("R8 register zero no dependency and R9 negative offset");
        set_prod(6, 0, 6, 0, 0, 6, 0);
        set_br(1, 6, 7, 1, 2, 4);
        step("R8 write flag clear and R10 advance");
        for (int i = 0; i < 600; i++) begin
            set_prod($urandom_range(0, 3), 1'($urandom), $urandom_range(0, 3), 1'($urandom),
                     1'($urandom), $urandom_range(0, 3), 1'($urandom));
            mem_alu_val = 32'($urandom_range(5, 6));
            wb_val      = 32'($urandom_range(5, 6));
            set_br(1'($urandom), $urandom_range(0, 3), $urandom_range(0, 3),
                   32'($urandom_range(5, 6)), 32'($urandom_range(5, 6)),
                   $urandom_range(0, 40) - 20);
            step("random");
        end
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule